// File: doc/BRIEF.md
# Pipelined multiply-accumulate unit

This block is the multiply-accumulate datapath of a small DSP core. It takes one pair of signed 16-bit operands on every clock and forms their full 32-bit product in a multiplier with three register stages. Each product is then added into a 40-bit running sum. A caller marks the first pair of a dot product with a start flag and the final pair with a last flag. The block then reports the finished sum with a one-cycle result-valid pulse.

The start and last flags travel through a shift register in step with the operands. The accumulator is therefore cleared exactly when the first product of a sequence leaves the multiplier, rather than when its operands enter. As a result, a new sequence can follow the previous one with no gap. Cycles with the input-valid strobe low are bubbles: they leave the sum and the flag alignment untouched.

Top module: `pipelined_mac`

## Requirements
- R1: Operands are two's-complement signed 16-bit values. Each product is the full signed 32-bit result, sign-extended to the 40-bit sum.
- R2: A pair is accepted on every clock. For N pairs presented on consecutive cycles starting at cycle 0, the complete sum appears on `accOut` with `resValid` high in cycle N+3. For a single pair this is the fourth clock edge counted from the edge that captured it.
- R3: When the product of a pair flagged with `inStart` reaches the accumulator, the earlier contents are discarded. On the following cycle `accOut` equals that product alone.
- R4: A cycle with `inValid` low adds nothing. The corresponding `accOut` update is skipped, so `accOut` keeps its value, and the timing of later pairs is unaffected.
- R5: `resValid` is high for one cycle per sequence, four clock edges after the pair flagged `inLast` was captured. `accOut` then holds the sum until the next valid product arrives.
- R6: A new sequence may start on the cycle right after the previous last pair. Both sums are reported correctly, in separate cycles.
- R7: Synchronous active-high `rst` clears every pipeline and flag register, the sum and `resValid`. A pair in flight when reset is asserted never produces a result.
- R8: The 8 guard bits allow 256 products of the largest magnitude, (-32768)*(-32768), to be summed without overflow: the result is 2^38.
- R9: `inStart` and `inLast` are ignored in a cycle where `inValid` is low. They neither clear the sum nor raise `resValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair on opA/opB is valid this cycle |
| inStart | input | 1 | This pair opens a new sum (qualified by inValid) |
| inLast | input | 1 | This pair closes the sum (qualified by inValid) |
| opA | input | 16 | Signed multiplicand |
| opB | input | 16 | Signed multiplier |
| accOut | output | 40 | Signed running sum of products |
| resValid | output | 1 | One-cycle pulse: accOut holds a finished sum |

## Verification
The bound checker checks the following on every cycle:
- a captured last pair always yields `resValid` four edges later, and `resValid` never rises without such a pair;
- a bubble leaves the sum frozen at the matching cycle;
- the value after a start-flagged product equals that product alone;
- reset leaves a zero sum with no result flag.

Only the bench scenarios can show the following:
- whole sums over long and back-to-back sequences, and the N+3 completion point;
- the guard-bit headroom at the extreme operand value;
- that flags on bubble cycles have no effect;
- that a pair caught by a mid-flight reset produces no result.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Default geometry of the unit
  parameter int unsigned DEF_OP_W    = 16;
  parameter int unsigned DEF_GUARD_W = 8;
  parameter int unsigned DEF_MUL_LAT = 3;

  // Strobes from the control path into the datapath, aligned to the
  // cycle in which a product leaves the last multiplier stage.
  typedef struct packed {
    logic addEn;     // product at the pipe end belongs to a valid pair
    logic clearSum;  // that product opens a new sequence
  } macStrobe_t;
endpackage

// File: rtl/mac_control.sv
module mac_control #(
  parameter int unsigned MUL_LAT = mac_pkg::DEF_MUL_LAT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic                inStart,
  input  logic                inLast,
  output mac_pkg::macStrobe_t strobes,
  output logic                resValid
);
  import mac_pkg::*;

  // Flags are qualified by the valid strobe before entering the delay line,
  // so bubble-cycle markers are dropped at the door.
  logic [MUL_LAT-1:0] vldSr;
  logic [MUL_LAT-1:0] startSr;
  logic [MUL_LAT-1:0] lastSr;
  logic               resValidQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      vldSr   <= '0;
      startSr <= '0;
      lastSr  <= '0;
    end else begin
      vldSr   <= {vldSr[MUL_LAT-2:0],   inValid};
      startSr <= {startSr[MUL_LAT-2:0], inValid & inStart};
      lastSr  <= {lastSr[MUL_LAT-2:0],  inValid & inLast};
    end
  end

  always_comb begin
    strobes.addEn    = vldSr[MUL_LAT-1];
    strobes.clearSum = startSr[MUL_LAT-1];
  end

  // The sum updates on the edge after the product leaves the multiplier;
  // the result flag is registered on that same edge.
  always_ff @(posedge clk) begin
    if (rst) resValidQ <= 1'b0;
    else     resValidQ <= lastSr[MUL_LAT-1];
  end

  assign resValid = resValidQ;
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int unsigned OP_W    = mac_pkg::DEF_OP_W,
  parameter int unsigned GUARD_W = mac_pkg::DEF_GUARD_W,
  parameter int unsigned MUL_LAT = mac_pkg::DEF_MUL_LAT,
  localparam int unsigned PROD_W = 2 * OP_W,
  localparam int unsigned ACC_W  = PROD_W + GUARD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  input  mac_pkg::macStrobe_t strobes,
  output logic [ACC_W-1:0]    accOut
);
  import mac_pkg::*;

  // Combinational signed multiply; the register chain behind it may be
  // retimed into the array by the implementation flow.
  logic signed [PROD_W-1:0] prodComb;
  logic signed [PROD_W-1:0] prodPipe [MUL_LAT];

  always_comb prodComb = $signed(opA) * $signed(opB);

  always_ff @(posedge clk) begin
    if (rst) prodPipe[0] <= '0;
    else     prodPipe[0] <= prodComb;
  end

  for (genvar s = 1; s < MUL_LAT; s++) begin : g_mulStage
    always_ff @(posedge clk) begin
      if (rst) prodPipe[s] <= '0;
      else     prodPipe[s] <= prodPipe[s-1];
    end
  end

  // Accumulator: one registered add; the old value is replaced by zero
  // when the arriving product opens a sequence.
  logic signed [ACC_W-1:0] prodExt;
  logic signed [ACC_W-1:0] sumBase;
  logic signed [ACC_W-1:0] sumQ;

  always_comb begin
    prodExt = {{GUARD_W{prodPipe[MUL_LAT-1][PROD_W-1]}}, prodPipe[MUL_LAT-1]};
    sumBase = strobes.clearSum ? '0 : sumQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                sumQ <= '0;
    else if (strobes.addEn) sumQ <= sumBase + prodExt;
  end

  assign accOut = sumQ;
endmodule

// File: rtl/pipelined_mac.sv
module pipelined_mac #(
  parameter int unsigned OP_W    = mac_pkg::DEF_OP_W,
  parameter int unsigned GUARD_W = mac_pkg::DEF_GUARD_W,
  parameter int unsigned MUL_LAT = mac_pkg::DEF_MUL_LAT,
  localparam int unsigned ACC_W  = 2 * OP_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inStart,
  input  logic             inLast,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [ACC_W-1:0] accOut,
  output logic             resValid
);
  import mac_pkg::*;

  macStrobe_t strobes;

  mac_control #(.MUL_LAT(MUL_LAT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inStart  (inStart),
    .inLast   (inLast),
    .strobes  (strobes),
    .resValid (resValid)
  );

  mac_datapath #(.OP_W(OP_W), .GUARD_W(GUARD_W), .MUL_LAT(MUL_LAT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .accOut  (accOut)
  );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inStart,
  input logic             inLast,
  input logic [OP_W-1:0]  opA,
  input logic [OP_W-1:0]  opB,
  input logic [ACC_W-1:0] accOut,
  input logic             resValid
);
  // Edges since reset released, saturating; gates looks four edges back.
  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  function automatic logic [ACC_W-1:0] refProd(input logic [OP_W-1:0] a,
                                               input logic [OP_W-1:0] b);
    logic signed [2*OP_W-1:0] p;
    p = $signed(a) * $signed(b);
    return ACC_W'(p);
  endfunction

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (accOut == '0 && !resValid));

  // R5
  last_gives_result_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd4 && $past(inValid && inLast, 4)) |-> resValid);

  // R9
  result_needs_last_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(inValid && inLast, 4));

  // R4
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd4 && !$past(inValid, 4)) |-> $stable(accOut));

  // R3
  first_product_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd4 && $past(inValid && inStart, 4)) |->
      (accOut == refProd($past(opA, 4), $past(opB, 4))));
endmodule

bind pipelined_mac mac_checker #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inStart  (inStart),
  .inLast   (inLast),
  .opA      (opA),
  .opB      (opB),
  .accOut   (accOut),
  .resValid (resValid)
);

// File: tb/pipelined_mac_tb.sv
module pipelined_mac_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, inStart, inLast;
  logic [15:0] opA, opB;
  logic [39:0] accOut;
  logic        resValid;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  pipelined_mac u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inStart(inStart),
    .inLast(inLast), .opA(opA), .opB(opB), .accOut(accOut),
    .resValid(resValid)
  );

  // {opA, opB, expected 32-bit signed product}; each entry is a one-pair sequence
  localparam int NV = 8;
  localparam logic [63:0] VEC [NV] = '{
    {16'h0003, 16'h0005, 32'h0000000F},
    {16'hFFFF, 16'h0001, 32'hFFFFFFFF},
    {16'h8000, 16'h8000, 32'h40000000},
    {16'h7FFF, 16'h8000, 32'hC0008000},
    {16'h0000, 16'h04D2, 32'h00000000},
    {16'hFFF9, 16'hFFF7, 32'h0000003F},
    {16'h7FFF, 16'h7FFF, 32'h3FFF0001},
    {16'h0064, 16'hFF38, 32'hFFFFB1E0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b,
                      input logic v, input logic s, input logic l);
    opA = a; opB = b; inValid = v; inStart = s; inLast = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic longint prodL(input logic [15:0] a, input logic [15:0] b);
    return longint'($signed(a)) * longint'($signed(b));
  endfunction

  function automatic logic [63:0] x40(input longint v);
    return {24'h0, v[39:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint sum;
    logic [15:0] a, b;
    rst = 1'b1; inValid = 0; inStart = 0; inLast = 0; opA = 0; opB = 0;
    @(negedge clk);
    repeat (3) idle();
    // R7: reset state
    chk("R7 reset accOut", x40(0) , {24'h0, accOut});
    chk("R7 reset resValid", 64'(resValid), 64'd0);
    rst = 1'b0;

    // R1 R6: table of single-pair sequences, issued back to back
    for (int k = 0; k < NV + 3; k++) begin
      if (k < NV) step(VEC[k][63:48], VEC[k][47:32], 1'b1, 1'b1, 1'b1);
      else        idle();
      if (k >= 3) begin
        chk("R1 table product", {24'h0, accOut}, x40(longint'($signed(VEC[k-3][31:0]))));
        chk("R6 table resValid", 64'(resValid), 64'd1);
      end
    end
    idle();
    chk("R5 pulse ends", 64'(resValid), 64'd0);

    // R2: 50 pairs on consecutive cycles, sum at cycle N+3
    sum = 0;
    for (int k = 0; k < 50; k++) begin
      a = 16'(k * 613 - 15000);
      b = 16'(20000 - k * 777);
      sum += prodL(a, b);
      step(a, b, 1'b1, k == 0, k == 49);
    end
    idle(); idle();
    chk("R2 not early", 64'(resValid), 64'd0);
    idle();
    chk("R2 sum of 50", {24'h0, accOut}, x40(sum));
    chk("R2 resValid at N+3", 64'(resValid), 64'd1);
    idle();
    chk("R5 one cycle", 64'(resValid), 64'd0);
    chk("R5 sum held", {24'h0, accOut}, x40(sum));

    // R6 R3: sequence of 3 then sequence of 2 with no gap
    step(16'd100, 16'd7, 1, 1, 0);
    step(16'hFF00, 16'd3, 1, 0, 0);
    step(16'd12, 16'd12, 1, 0, 1);
    step(16'hFFFE, 16'd1000, 1, 1, 0);
    step(16'd9, 16'hFFF6, 1, 0, 1);
    idle();
    chk("R6 first sum", {24'h0, accOut}, x40(700 - 768 + 144));
    chk("R6 first valid", 64'(resValid), 64'd1);
    idle();
    chk("R3 cleared to first product", {24'h0, accOut}, x40(-2000));
    chk("R6 no valid between", 64'(resValid), 64'd0);
    idle();
    chk("R6 second sum", {24'h0, accOut}, x40(-2090));
    chk("R6 second valid", 64'(resValid), 64'd1);

    // R4 R9: bubbles carrying operands and stray markers
    step(16'd5, 16'd6, 1, 1, 0);
    step(16'd999, 16'd999, 0, 1, 1);
    step(16'd4, 16'd4, 1, 0, 0);
    step(16'h7FFF, 16'h7FFF, 0, 1, 0);
    step(16'd2, 16'hFFFD, 1, 0, 1);
    idle(); idle();
    chk("R4 bubble sum before last", {24'h0, accOut}, x40(46));
    chk("R9 bubble last ignored", 64'(resValid), 64'd0);
    idle();
    chk("R4 bubble sum", {24'h0, accOut}, x40(40));
    chk("R4 bubble resValid", 64'(resValid), 64'd1);
    step(16'd50, 16'd50, 0, 1, 1);
    repeat (4) idle();
    chk("R9 marker on bubble no clear", {24'h0, accOut}, x40(40));
    chk("R9 marker on bubble no result", 64'(resValid), 64'd0);

    // R8: 256 extreme products
    for (int k = 0; k < 256; k++) step(16'h8000, 16'h8000, 1, k == 0, k == 255);
    repeat (3) idle();
    chk("R8 guard headroom", {24'h0, accOut}, x40(longint'(1) << 38));
    chk("R8 resValid", 64'(resValid), 64'd1);

    // R7: reset while a pair is in flight
    step(16'd5, 16'd5, 1, 1, 1);
    rst = 1'b1;
    idle();
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      idle();
      chk("R7 no result after reset", 64'(resValid), 64'd0);
    end
    chk("R7 sum zero after reset", {24'h0, accOut}, x40(0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule